// File: doc/BRIEF.md
# Delay-Line Tap Wrap Guard

This block watches the tap-select index that a digital delay-locked loop drives into its delay line. The loop moves the index up and down to stay in phase. If it runs past the end of the line it wraps to the first tap, and the loop is then working improperly. The guard samples the index whenever a valid strobe accompanies it. It reports two conditions:

- an index sitting on the final tap, which is a potential wrap;
- a move from the final tap straight to tap zero, which is an actual wrap.

The guard has a detect-enable input. When it is high, either condition latches a checkstop output that stays high until reset. Detection can be turned on together with the loop to catch trouble during initial synchronisation. It can also be turned on later, once the loop has locked and the downstream cache is running. Conditions seen while detection is off are only reported on the status outputs and are never held for later.

The tap count is a parameter, `TAPS` (default 128). The index width is derived from it.

Top module: `dtg_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, all three outputs go low at that edge. Directly after reset, the guard holds no earlier index in its history.
- R2: A sample with `tap_vld`=1, `dll_en`=1 and `tap_idx`=`TAPS`-1 raises `near_end` for exactly the one cycle after that edge. Every further such sample raises it again.
- R3: A sample with `tap_vld`=1, `dll_en`=1 and `tap_idx`=0 raises `wrapped` for the one cycle after that edge, when the most recent earlier valid sample was `TAPS`-1. Cycles with `tap_vld`=0 in between do not break this history.
- R4: A valid index of 0 raises no `wrapped` in three cases: it follows any valid index other than `TAPS`-1; it is the first valid sample since reset; or the index moves from `TAPS`-1 to any value other than 0.
- R5: While `tap_vld` is low, `tap_idx` is ignored. It raises no flag and does not replace the remembered index.
- R6: While `dll_en` is low, no flag is raised and the remembered index is forgotten. A `TAPS`-1 seen before the loop was disabled does not pair with a 0 seen after it is enabled again.
- R7: With `detect_en` high at the edge that samples a potential wrap or an actual wrap, `checkstop` goes high in the following cycle.
- R8: Once high, `checkstop` stays high regardless of any input until `rst_n` is low at a clock edge.
- R9: A potential or actual wrap sampled while `detect_en` is low never sets `checkstop`, either then or after `detect_en` rises later.
- R10: `near_end` and `wrapped` report conditions the same way whether `detect_en` is high or low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| detect_en | input | 1 | Enables escalation of wrap conditions to checkstop |
| dll_en | input | 1 | Delay-locked loop enabled; low clears the history and mutes the flags |
| tap_idx | input | $clog2(TAPS) | Tap index selected by the loop |
| tap_vld | input | 1 | `tap_idx` is meaningful this cycle |
| checkstop | output | 1 | Sticky fatal indication |
| near_end | output | 1 | One-cycle pulse: the final tap was sampled |
| wrapped | output | 1 | One-cycle pulse: the index wrapped from the final tap to tap 0 |

## Verification
The guard keeps only one internal state that carries between samples: the remembered last valid index and whether it is present. A wrong value there shows up at the port in the cycle right after the next valid 0, as a `wrapped` pulse that should not be there or that is missing. With detection enabled, that same cycle also shows a wrong `checkstop`. The latched checkstop bit is the other state. Any leak or early clear of it is visible on `checkstop` in the very next cycle, and it remains visible until reset.

// File: rtl/dtg_pkg.sv
// Package: shared types for the delay-line tap wrap guard.
// Assumes nothing beyond standard SystemVerilog packed types.
package dtg_pkg;

    // Per-sample classification of the tap index stream.
    typedef struct packed {
        logic near_end;   // index equals the final tap
        logic wrapped;    // index went from the final tap to tap zero
    } tap_event_t;

endpackage

// File: rtl/dtg_tap_history.sv
// Module: dtg_tap_history
// Remembers the most recent valid tap index while the loop is enabled.
// Assumes: rst_n is synchronous active-low. Dropping dll_en forgets history,
// so a wrap cannot be paired across a loop disable.
module dtg_tap_history #(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dll_en,
    input  logic             tap_vld,
    input  logic [IDX_W-1:0] tap_idx,
    output logic [IDX_W-1:0] prev_idx,
    output logic             prev_ok
);

    // Capture each valid index; clear the presence bit on reset or loop disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_idx <= '0;
            prev_ok  <= 1'b0;
        end else if (!dll_en) begin
            prev_ok  <= 1'b0;
        end else if (tap_vld) begin
            prev_idx <= tap_idx;
            prev_ok  <= 1'b1;
        end
    end

endmodule

// File: rtl/dtg_classify.sv
// Module: dtg_classify
// Purely combinational classifier of the current sample against history.
// Assumes: the history is supplied by dtg_tap_history and is valid only
// when prev_ok is high.
module dtg_classify
    import dtg_pkg::*;
#(
    parameter int TAPS  = 128,
    parameter int IDX_W = 7
) (
    input  logic             dll_en,
    input  logic             tap_vld,
    input  logic [IDX_W-1:0] tap_idx,
    input  logic [IDX_W-1:0] prev_idx,
    input  logic             prev_ok,
    output tap_event_t       ev
);

    localparam logic [IDX_W-1:0] LAST_TAP  = IDX_W'(TAPS - 1);
    localparam logic [IDX_W-1:0] FIRST_TAP = '0;

    logic sample_live;

    // Decide whether this cycle's index is a potential or an actual wrap.
    always_comb begin
        sample_live = dll_en && tap_vld;
        ev.near_end = sample_live && (tap_idx == LAST_TAP);
        ev.wrapped  = sample_live && (tap_idx == FIRST_TAP)
                      && prev_ok && (prev_idx == LAST_TAP);
    end

endmodule

// File: rtl/dtg_flag_reg.sv
// Module: dtg_flag_reg
// Registers the per-sample status pulses and the sticky checkstop.
// Assumes: ev is combinational from the same cycle's inputs; detect_en is
// sampled at the same edge, so disabled-period events leave no trace.
module dtg_flag_reg
    import dtg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       detect_en,
    input  tap_event_t ev,
    output logic       near_end,
    output logic       wrapped,
    output logic       checkstop
);

    logic trip;

    // Escalation condition: any wrap class while detection is armed.
    always_comb trip = detect_en && (ev.near_end || ev.wrapped);

    // Status pulses follow the classifier by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            near_end <= 1'b0;
            wrapped  <= 1'b0;
        end else begin
            near_end <= ev.near_end;
            wrapped  <= ev.wrapped;
        end
    end

    // Checkstop latches on a trip and only reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)    checkstop <= 1'b0;
        else if (trip) checkstop <= 1'b1;
    end

endmodule

// File: rtl/dtg_top.sv
// Module: dtg_top
// Delay-line tap wrap guard: flags a potential wrap (final tap) and an actual
// wrap (final tap followed by tap zero) and escalates either to a sticky
// checkstop when detection is enabled.
// Assumes: tap_idx is synchronous to clk; rst_n is synchronous active-low.
module dtg_top
    import dtg_pkg::*;
#(
    parameter int TAPS = 128
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   detect_en,
    input  logic                                   dll_en,
    input  logic [((TAPS > 1) ? $clog2(TAPS) : 1)-1:0] tap_idx,
    input  logic                                   tap_vld,
    output logic                                   checkstop,
    output logic                                   near_end,
    output logic                                   wrapped
);

    localparam int IDX_W = (TAPS > 1) ? $clog2(TAPS) : 1;
    localparam logic [IDX_W-1:0] LAST_TAP = IDX_W'(TAPS - 1);

    logic [IDX_W-1:0] prev_idx;
    logic             prev_ok;
    tap_event_t       ev;

    dtg_tap_history #(.IDX_W(IDX_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .dll_en   (dll_en),
        .tap_vld  (tap_vld),
        .tap_idx  (tap_idx),
        .prev_idx (prev_idx),
        .prev_ok  (prev_ok)
    );

    dtg_classify #(.TAPS(TAPS), .IDX_W(IDX_W)) u_cls (
        .dll_en   (dll_en),
        .tap_vld  (tap_vld),
        .tap_idx  (tap_idx),
        .prev_idx (prev_idx),
        .prev_ok  (prev_ok),
        .ev       (ev)
    );

    dtg_flag_reg u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .detect_en (detect_en),
        .ev        (ev),
        .near_end  (near_end),
        .wrapped   (wrapped),
        .checkstop (checkstop)
    );

    // Potential-wrap pulse only follows a live final-tap sample.
    assert_near_end_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        near_end |-> $past(tap_vld && dll_en && (tap_idx == LAST_TAP)));

    // Actual-wrap pulse only follows a live sample of tap zero.
    assert_wrap_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wrapped |-> $past(tap_vld && dll_en && (tap_idx == '0)));

    // No status while the loop was disabled.
    assert_quiet_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(dll_en) |-> (!near_end && !wrapped));

    // Checkstop is only armed by an enabled detection.
    assert_trip_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(checkstop) |-> $past(detect_en));

    // Checkstop never drops outside reset.
    assert_checkstop_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(checkstop) |-> checkstop);

    // An enabled event always escalates.
    assert_trip_on_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (detect_en && (ev.near_end || ev.wrapped)) |=> checkstop);

endmodule

// File: tb/dtg_top_test.sv
`timescale 1ns/1ps
module dtg_top_test;

    localparam int TAPS  = 128;
    localparam int IDX_W = $clog2(TAPS);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(TAPS - 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             detect_en = 1'b0;
    logic             dll_en = 1'b0;
    logic [IDX_W-1:0] tap_idx = '0;
    logic             tap_vld = 1'b0;
    logic             checkstop, near_end, wrapped;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    dtg_top #(.TAPS(TAPS)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .detect_en (detect_en),
        .dll_en    (dll_en),
        .tap_idx   (tap_idx),
        .tap_vld   (tap_vld),
        .checkstop (checkstop),
        .near_end  (near_end),
        .wrapped   (wrapped)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Drive a sample before the edge; return after the edge with outputs settled.
    task automatic step(input logic vld, input logic [IDX_W-1:0] idx);
        tap_vld = vld;
        tap_idx = idx;
        @(negedge clk);
        tap_vld = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        detect_en = 1'b0;
        dll_en = 1'b0;
        tap_vld = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "checkstop", checkstop, 1'b0);
        chk("R1", "near_end", near_end, 1'b0);
        chk("R1", "wrapped", wrapped, 1'b0);
    endtask

    task automatic t_status_flags();
        do_reset();
        dll_en = 1'b1;
        step(1'b1, LAST);
        chk("R2", "near_end after final tap", near_end, 1'b1);
        chk("R10", "near_end with detect off", near_end, 1'b1);
        step(1'b1, LAST);
        chk("R2", "near_end repeat", near_end, 1'b1);
        step(1'b0, LAST);
        chk("R5", "near_end on invalid index", near_end, 1'b0);
        step(1'b0, 7'd9);
        step(1'b1, '0);
        chk("R3", "wrapped after gap", wrapped, 1'b1);
        chk("R2", "near_end clear on tap0", near_end, 1'b0);
        step(1'b1, '0);
        chk("R3", "wrapped is one pulse", wrapped, 1'b0);
        chk("R9", "checkstop with detect off", checkstop, 1'b0);
    endtask

    task automatic t_no_wrap();
        do_reset();
        dll_en = 1'b1;
        step(1'b1, '0);
        chk("R4", "first sample tap0", wrapped, 1'b0);
        step(1'b1, 7'd5);
        step(1'b1, '0);
        chk("R4", "tap0 after mid index", wrapped, 1'b0);
        step(1'b1, LAST);
        step(1'b1, LAST - 7'd1);
        chk("R4", "final tap then lower", wrapped, 1'b0);
        step(1'b1, '0);
        chk("R4", "tap0 after descend", wrapped, 1'b0);
        step(1'b1, LAST);
        step(1'b0, 7'd3);
        step(1'b1, '0);
        chk("R5", "invalid index kept history", wrapped, 1'b1);
    endtask

    task automatic t_dll_off();
        do_reset();
        dll_en = 1'b1;
        step(1'b1, LAST);
        dll_en = 1'b0;
        step(1'b1, LAST);
        chk("R6", "near_end with loop off", near_end, 1'b0);
        step(1'b1, '0);
        chk("R6", "wrapped with loop off", wrapped, 1'b0);
        dll_en = 1'b1;
        step(1'b1, '0);
        chk("R6", "history forgotten", wrapped, 1'b0);
    endtask

    task automatic t_late_enable();
        do_reset();
        dll_en = 1'b1;
        step(1'b1, LAST);
        step(1'b1, '0);
        chk("R10", "wrapped with detect off", wrapped, 1'b1);
        detect_en = 1'b1;
        for (int i = 0; i < 4; i++) step(1'b1, 7'd20);
        chk("R9", "no deferred checkstop", checkstop, 1'b0);
    endtask

    task automatic t_trip_potential();
        do_reset();
        dll_en = 1'b1;
        detect_en = 1'b1;
        step(1'b1, 7'd40);
        chk("R7", "no trip on ordinary index", checkstop, 1'b0);
        step(1'b1, LAST);
        chk("R7", "trip on final tap", checkstop, 1'b1);
        detect_en = 1'b0;
        dll_en = 1'b0;
        for (int i = 0; i < 5; i++) step(1'b1, 7'd1);
        chk("R8", "checkstop held", checkstop, 1'b1);
        do_reset();
        chk("R8", "checkstop cleared by reset", checkstop, 1'b0);
    endtask

    task automatic t_trip_wrap();
        do_reset();
        dll_en = 1'b1;
        step(1'b1, LAST);
        chk("R9", "final tap with detect off", checkstop, 1'b0);
        detect_en = 1'b1;
        step(1'b1, '0);
        chk("R7", "trip on actual wrap", checkstop, 1'b1);
        chk("R3", "wrapped with detect on", wrapped, 1'b1);
    endtask

    initial begin
        t_reset();
        t_status_flags();
        t_no_wrap();
        t_dll_off();
        t_late_enable();
        t_trip_potential();
        t_trip_wrap();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule